// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from two groups of sources. One group holds four user request lines and the other holds four counter terminal-count lines. It merges them into a single request line to the host processor. Each source has two settings: a block bit, which keeps it out of arbitration, and a sensitivity bit, which selects rising-edge or level detection.

Among the sources that are pending and not blocked, the one with the lowest index wins. Its index is offered to the host as a 3-bit vector. When the host reads the vector through the small register port, the pending state of the winning source is withdrawn automatically. This lets an interrupt handler find and acknowledge its cause with one read.

The register port has four word addresses. Address 0 holds the block bits and address 1 holds the sensitivity bits; both can be written and read. Address 2 returns the pending state and can only be read. Address 3 returns the vector, and reading it acknowledges the winning source. Read data is combinational and valid during the cycle in which the read strobe is high. Any side effect of a read or write takes place at the clock edge that ends that cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all block bits read 1 (0xFF at address 0), all sensitivity bits read 0 (edge mode, 0x00 at address 1), pending reads 0x00, a vector read returns 0x00 and `irq` is low.
- R2: A source in edge mode becomes pending at the clock edge that first samples its input high after sampling it low. It stays pending after the input falls, until it is acknowledged.
- R3: A source in level mode (sensitivity bit 1) has a pending bit equal to its input as sampled at the previous clock edge. A vector read does not remove it while the input stays high.
- R4: Block bit i (address 0, bit i; 1 blocks) keeps source i out of `irq` and out of the vector. Its pending bit is still recorded and is visible at address 2.
- R5: `irq` is high exactly when at least one pending source is not blocked.
- R6: Among pending, unblocked sources the lowest index wins. User lines take indices 0 to 3 (`usr_req[i]` is index i). Terminal-count lines take indices 4 to 7 (`tc_req[j]` is index 4+j).
- R7: A read of address 3 returns bit 7 as a valid flag, bits 2:0 as the winning index, and zeros in bits 6:3.
- R8: A read of address 3 with a valid result clears the pending bit of the winning edge-mode source at the end of that cycle. Other sources are not affected.
- R9: A read of address 3 with no unblocked pending source returns 0x00 and leaves every pending bit unchanged.
- R10: If an edge-mode source sees a new rising edge in the same cycle that a vector read acknowledges it, the source stays pending.
- R11: Writes to address 0 and address 1 take effect at the end of the write cycle, and each value reads back unchanged.
- R12: Writes to address 2 or address 3 change no register and no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| usr_req | input | 4 | User request lines, indices 0 to 3 |
| tc_req | input | 4 | Counter terminal-count lines, indices 4 to 7 |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | 2 | Word address: 0 block, 1 sensitivity, 2 pending, 3 vector |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is strobed |
| irq | output | 1 | Request to the host |

## Verification
The bench builds the block with its default split of four user lines and four terminal-count lines. That gives eight sources, a 3-bit vector and an 8-bit register word, so every priority index, both source groups, the vector's valid flag and the bit-wise block and sensitivity fields are all exercised. A behavioural model predicts `irq` and the read data on every cycle. Directed sequences cover priority order across the two groups, blocked sources that remain pending, level sources that persist through acknowledge, an edge that collides with its own acknowledge, and writes to the read-only addresses.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the prioritized interrupt controller.
// Assumes a two-bit word address on the register port.
package irq_prio_pkg;
    localparam logic [1:0] ADDR_BLOCK = 2'd0;
    localparam logic [1:0] ADDR_SENSE = 2'd1;
    localparam logic [1:0] ADDR_PEND  = 2'd2;
    localparam logic [1:0] ADDR_VEC   = 2'd3;
endpackage

// File: rtl/irq_src_cell.sv
// One interrupt source: edge detection and the pending flag.
// Assumes req_in is already synchronous to clk. In level mode the pending bit
// follows the sampled input. In edge mode a new rising edge takes priority
// over an acknowledge in the same cycle.
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic level_mode,
    input  logic ack,
    output logic pend
);
    logic prev_q;
    logic rise;

    // rising edge compared against the previously sampled input
    assign rise = req_in & ~prev_q;

    // pending flag and input history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= req_in;
            if (level_mode)
                pend <= req_in;
            else
                pend <= rise | (pend & ~ack);
        end
    end

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && req_in && !prev_q) |=> pend);
    assert_edge_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && pend && !ack) |=> pend);
    assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (pend == $past(req_in)));
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && ack && !(req_in && !prev_q)) |=> !pend);
    assert_edge_beats_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && ack && req_in && !prev_q) |=> pend);
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: lowest set index wins.
// Assumes N is at least 2. The clock and reset are used only by the checks.
module irq_prio_enc #(
    parameter int N = 8,
    localparam int VW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  active,
    output logic          valid,
    output logic [VW-1:0] vec
);
    // scan from the lowest priority upward so the lowest index is written last
    always_comb begin
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) vec = VW'(i);
        end
    end

    // any active request makes the vector meaningful
    assign valid = |active;

    assert_winner_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> active[vec]);
    assert_no_higher_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((active & ((N'(1) << vec) - N'(1))) == '0));
endmodule

// File: rtl/irq_cfg_regs.sv
// Block and sensitivity registers plus the read multiplexer.
// Assumes one read or write per cycle. Read data is combinational while bus_rd is high.
module irq_cfg_regs
    import irq_prio_pkg::*;
#(
    parameter int N = 8,
    localparam int VW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [N-1:0]  bus_wdata,
    input  logic [N-1:0]  pend,
    input  logic          vec_valid,
    input  logic [VW-1:0] vec,
    output logic [N-1:0]  block,
    output logic [N-1:0]  sense,
    output logic [N-1:0]  rdata
);
    // configuration registers, written only at their own addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block <= '1;
            sense <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_BLOCK) block <= bus_wdata;
            if (bus_addr == ADDR_SENSE) sense <= bus_wdata;
        end
    end

    // read multiplexer; the vector word puts valid in the top bit
    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_BLOCK: rdata = block;
                ADDR_SENSE: rdata = sense;
                ADDR_PEND:  rdata = pend;
                default: if (vec_valid) begin
                    rdata[N-1]  = 1'b1;
                    rdata[VW-1:0] = vec;
                end
            endcase
        end
    end

    assert_block_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_BLOCK) |=> (block == $past(bus_wdata)));
    assert_sense_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_SENSE) |=> (sense == $past(bus_wdata)));
    assert_ro_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1]) |=> ($stable(block) && $stable(sense)));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Prioritized interrupt controller: user and terminal-count sources, each
// with its own block bit and sensitivity bit. Reading the vector acknowledges
// the winning source. Assumes all request inputs are synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int USR_N = 4,
    parameter int TC_N  = 4,
    localparam int N  = USR_N + TC_N,
    localparam int VW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [USR_N-1:0] usr_req,
    input  logic [TC_N-1:0]  tc_req,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [N-1:0]     bus_wdata,
    output logic [N-1:0]     bus_rdata,
    output logic             irq
);
    logic [N-1:0]  src;
    logic [N-1:0]  pend;
    logic [N-1:0]  block;
    logic [N-1:0]  sense;
    logic [N-1:0]  active;
    logic [N-1:0]  ack;
    logic          vec_valid;
    logic [VW-1:0] vec;
    logic          vec_read;

    // user lines take the high-priority low indices
    assign src = {tc_req, usr_req};

    // sources that take part in arbitration
    assign active = pend & ~block;

    // a valid vector read acknowledges exactly the winner
    assign vec_read = bus_rd && (bus_addr == ADDR_VEC) && vec_valid;
    assign ack = vec_read ? (N'(1) << vec) : '0;

    // request to the host
    assign irq = vec_valid;

    for (genvar g = 0; g < N; g++) begin : g_src
        irq_src_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_in     (src[g]),
            .level_mode (sense[g]),
            .ack        (ack[g]),
            .pend       (pend[g])
        );
    end

    irq_prio_enc #(.N(N)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .valid  (vec_valid),
        .vec    (vec)
    );

    irq_cfg_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend      (pend),
        .vec_valid (vec_valid),
        .vec       (vec),
        .block     (block),
        .sense     (sense),
        .rdata     (bus_rdata)
    );

    assert_irq_unblocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend[vec] && !block[vec]));
    assert_blocked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~block) == '0) |-> !irq);
    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] usr_req = '0;
    logic [3:0] tc_req = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    logic [7:0] m_block = 8'hFF;
    logic [7:0] m_sense = 8'h00;
    logic [7:0] m_pend  = 8'h00;
    logic [7:0] m_prev  = 8'h00;

    always #4 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .tc_req(tc_req),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int m_winner();
        for (int i = 0; i < 8; i++)
            if (m_pend[i] && !m_block[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] m_rdata();
        int w;
        if (!bus_rd) return 8'h00;
        case (bus_addr)
            2'd0: return m_block;
            2'd1: return m_sense;
            2'd2: return m_pend;
            default: begin
                w = m_winner();
                if (w < 0) return 8'h00;
                return 8'h80 | 8'(w);
            end
        endcase
    endfunction

    // reference update at each rising edge
    always @(posedge clk) begin
        logic [7:0] s;
        int w;
        s = {tc_req, usr_req};
        if (!rst_n) begin
            m_block = 8'hFF; m_sense = 8'h00; m_pend = 8'h00; m_prev = 8'h00;
        end else begin
            w = m_winner();
            for (int i = 0; i < 8; i++) begin
                if (m_sense[i]) m_pend[i] = s[i];
                else if (s[i] && !m_prev[i]) m_pend[i] = 1'b1;
                else if (bus_rd && bus_addr == 2'd3 && w == i) m_pend[i] = 1'b0;
            end
            m_prev = s;
            if (bus_wr && bus_addr == 2'd0) m_block = bus_wdata;
            if (bus_wr && bus_addr == 2'd1) m_sense = bus_wdata;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive after the falling edge, compare mid-phase with the model
    task automatic cyc(input string tag, input logic rd, input logic wr,
                       input logic [1:0] a, input logic [7:0] wd,
                       input logic [3:0] u, input logic [3:0] t,
                       output logic [7:0] got);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        usr_req = u; tc_req = t;
        #2;
        check({tag, " irq"}, {7'd0, irq}, {7'd0, (m_winner() >= 0)});
        check({tag, " rdata"}, bus_rdata, m_rdata());
        got = bus_rdata;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        cyc("R1", 1, 0, 2'd0, 0, 0, 0, r); check("R1 block", r, 8'hFF);
        cyc("R1", 1, 0, 2'd1, 0, 0, 0, r); check("R1 sense", r, 8'h00);
        cyc("R1", 1, 0, 2'd2, 0, 0, 0, r); check("R1 pend", r, 8'h00);
        cyc("R1", 1, 0, 2'd3, 0, 0, 0, r); check("R1 vec", r, 8'h00);
        // R11 write and read back
        cyc("R11", 0, 1, 2'd0, 8'h00, 0, 0, r);
        cyc("R11", 1, 0, 2'd0, 0, 0, 0, r); check("R11 block", r, 8'h00);
        // R2 edge latch on user line 2, held after the input falls
        cyc("R2", 0, 0, 0, 0, 4'b0100, 0, r);
        cyc("R2", 0, 0, 0, 0, 0, 0, r);
        cyc("R2", 1, 0, 2'd2, 0, 0, 0, r); check("R2 pend", r, 8'h04);
        check("R5 irq", {7'd0, irq}, 8'h01);
        // R7 and R8: vector read and acknowledge
        cyc("R7", 1, 0, 2'd3, 0, 0, 0, r); check("R7 vec", r, 8'h82);
        cyc("R8", 1, 0, 2'd2, 0, 0, 0, r); check("R8 pend", r, 8'h00);
        // R6 priority across groups: index 5 and index 3
        cyc("R6", 0, 0, 0, 0, 4'b1000, 4'b0010, r);
        cyc("R6", 1, 0, 2'd3, 0, 0, 0, r); check("R6 first", r, 8'h83);
        cyc("R6", 1, 0, 2'd3, 0, 0, 0, r); check("R6 second", r, 8'h85);
        cyc("R6", 1, 0, 2'd3, 0, 0, 0, r); check("R6 empty", r, 8'h00);
        // R4 and R9: blocked source still pending, empty read clears nothing
        cyc("R4", 0, 1, 2'd0, 8'h08, 0, 0, r);
        cyc("R4", 0, 0, 0, 0, 4'b1000, 0, r);
        cyc("R4", 1, 0, 2'd2, 0, 0, 0, r); check("R4 pend", r, 8'h08);
        check("R4 irq", {7'd0, irq}, 8'h00);
        cyc("R9", 1, 0, 2'd3, 0, 0, 0, r); check("R9 vec", r, 8'h00);
        cyc("R9", 1, 0, 2'd2, 0, 0, 0, r); check("R9 pend", r, 8'h08);
        cyc("R5", 0, 1, 2'd0, 8'h00, 0, 0, r);
        cyc("R5", 0, 0, 0, 0, 0, 0, r); check("R5 irq", {7'd0, irq}, 8'h01);
        cyc("R8", 1, 0, 2'd3, 0, 0, 0, r); check("R8 vec", r, 8'h83);
        // R3 level source 0 survives acknowledge while high
        cyc("R3", 0, 1, 2'd1, 8'h01, 0, 0, r);
        cyc("R3", 0, 0, 0, 0, 4'b0001, 0, r);
        cyc("R3", 1, 0, 2'd3, 0, 4'b0001, 0, r); check("R3 vec", r, 8'h80);
        cyc("R3", 1, 0, 2'd2, 0, 4'b0001, 0, r); check("R3 held", r, 8'h01);
        cyc("R3", 0, 0, 0, 0, 0, 0, r);
        cyc("R3", 1, 0, 2'd2, 0, 0, 0, r); check("R3 drop", r, 8'h00);
        // R10 new edge in the acknowledge cycle wins (user line 1)
        cyc("R10", 0, 0, 0, 0, 4'b0010, 0, r);
        cyc("R10", 0, 0, 0, 0, 0, 0, r);
        cyc("R10", 1, 0, 2'd3, 0, 4'b0010, 0, r); check("R10 vec", r, 8'h81);
        cyc("R10", 1, 0, 2'd2, 0, 0, 0, r); check("R10 pend", r, 8'h02);
        // R12 writes to read-only addresses change nothing
        cyc("R12", 0, 1, 2'd2, 8'hFF, 0, 0, r);
        cyc("R12", 0, 1, 2'd3, 8'hFF, 0, 0, r);
        cyc("R12", 1, 0, 2'd2, 0, 0, 0, r); check("R12 pend", r, 8'h02);
        cyc("R12", 1, 0, 2'd0, 0, 0, 0, r); check("R12 block", r, 8'h00);
        cyc("R12", 1, 0, 2'd1, 0, 0, 0, r); check("R12 sense", r, 8'h01);
        cyc("idle", 0, 0, 0, 0, 0, 0, r);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule